// File: doc/BRIEF.md
# CPU-Space Cycle Breakpoint Sequencer

This block issues the special CPU-space bus cycles of a small microcontroller bus interface. A hardware breakpoint request is sampled together with incoming read data and marks the pipeline entry that data belongs to. A mark on an instruction prefetch travels with that instruction through a small tag queue. A mark on an operand fetch attaches to the instruction now executing. When a marked instruction retires, the block starts a word read in CPU space that acknowledges the breakpoint. When that read is terminated, normally or with a bus error, it raises a one-cycle breakpoint exception entry.

The same bus sequencer also produces interrupt acknowledge cycles from a level request and a low-power stop broadcast from a stop request. Only one CPU-space cycle is outstanding at a time. Requests that arrive while a cycle runs wait for it to finish. The pipeline and the bus slave are modelled by simple pulse and level ports. A fetch is one cycle of `rd_valid`. A retire is one cycle of `ins_retire`. The slave ends a cycle with one cycle of `bus_ack` or `bus_err`.

Top module: `cpu_space_seq`

## Requirements
- R1: While reset is asserted, and after reset until a request arrives, `cs_req`, `cs_fc`, `cs_addr`, `bkpt_exc` and `cyc_done` are all zero.
- R2: A prefetch (`rd_valid`=1, `rd_prefetch`=1) with `bkpt_in`=1 tags that instruction. Retire pulses for older, untagged instructions start no cycle. `cs_req` is high in the cycle after the retire pulse of the tagged instruction.
- R3: An operand fetch (`rd_valid`=1, `rd_prefetch`=0) with `bkpt_in`=1 tags the executing instruction. `cs_req` is high in the cycle after its next retire pulse, and not before.
- R4: `pipe_flush` discards every tag of an instruction that has not yet retired, including a tag arriving in the same cycle. Later retire pulses then start no acknowledge cycle.
- R5: The breakpoint acknowledge cycle drives `cs_fc`=3'b111 and `cs_addr`=24'h00001E. In that address, bits [19:16]=0, bits [4:2]=7 (breakpoint number) and bit [1]=1 (type bit).
- R6: An acknowledge cycle ended by either `bus_ack` or `bus_err` drops `cs_req` and pulses `bkpt_exc` for exactly one cycle, both in the cycle after the termination.
- R7: An interrupt acknowledge drives `cs_fc`=3'b111. Its address has bits [23:4] all one, `iack_level` in bits [3:1] and bit [0]=1. Level 5 gives 24'hFFFFFB.
- R8: A stop broadcast drives `cs_fc`=3'b111 and `cs_addr`=24'h03FFFE. Bits [17:1] are one and all other bits are zero.
- R9: Requests present together are served in this order: breakpoint acknowledge, then interrupt acknowledge, then stop broadcast.
- R10: `cs_req` stays high until a termination arrives. `cs_addr` and `cs_fc` do not change during the cycle.
- R11: While a cycle runs, no other starts. A breakpoint that retires during another cycle is held, and its acknowledge starts in the cycle after that cycle ends.
- R12: With no cycle running, `cs_addr` and `cs_fc` are zero. A termination input then has no effect on `cs_req`, `bkpt_exc` or `cyc_done`.
- R13: `cyc_done` pulses for one cycle after the termination of any CPU-space cycle. `bkpt_exc` pulses only when the terminated cycle was a breakpoint acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_valid | input | 1 | Read data arrives this cycle |
| rd_prefetch | input | 1 | 1: the read is an instruction prefetch, 0: an operand fetch |
| bkpt_in | input | 1 | Breakpoint request, sampled with `rd_valid` |
| ins_retire | input | 1 | The oldest instruction finishes execution |
| pipe_flush | input | 1 | Discard all unretired pipeline entries |
| iack_req | input | 1 | Interrupt acknowledge request, held until `cyc_done` |
| iack_level | input | 3 | Interrupt level being acknowledged |
| stop_req | input | 1 | Low-power stop broadcast request, held until `cyc_done` |
| bus_ack | input | 1 | Normal termination of the running cycle |
| bus_err | input | 1 | Error termination of the running cycle |
| cs_req | output | 1 | CPU-space cycle in progress |
| cs_fc | output | 3 | Function code, 3'b111 during a cycle |
| cs_addr | output | 24 | CPU-space address |
| bkpt_exc | output | 1 | One-cycle breakpoint exception entry |
| cyc_done | output | 1 | One-cycle pulse when any cycle ends |

## Verification
The hardest case to reach is a breakpoint that retires while another CPU-space cycle is still running. Its acknowledge must be held and must start only after that cycle terminates. The bench reaches this case by queuing a tagged prefetch and then opening a stop broadcast. It pulses retire during that broadcast and checks that the address stays the stop code until termination. Two cycles after the termination it checks for the acknowledge address. A second hard case is a tag that must vanish through a flush. The bench tags both a queued prefetch and the executing instruction, flushes, and then retires several times while watching `cs_req`.

// File: rtl/cpu_space_pkg.sv
package cpu_space_pkg;
  localparam int CS_AW  = 24;
  localparam int FC_W   = 3;
  localparam int LVL_W  = 3;
  localparam logic [FC_W-1:0] FC_CPU_SPACE = 3'b111;
  localparam logic [FC_W-1:0] FC_NONE      = 3'b000;

  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_BKPT = 2'd1,
    CYC_IACK = 2'd2,
    CYC_STOP = 2'd3
  } cyc_kind_e;

  typedef enum logic {
    BUS_IDLE   = 1'b0,
    BUS_ACTIVE = 1'b1
  } bus_state_e;
endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cs_bkpt_tagger.sv
module cs_bkpt_tagger #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_vld,
  input  logic fetch_pre,
  input  logic bkpt_in,
  input  logic retire,
  input  logic flush,
  input  logic bp_grant,
  output logic bp_want
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] tag_q, tag_d;
  logic [CW-1:0]    cnt_q, cnt_d, cnt_ap;
  logic             op_q, op_d;
  logic             pend_q, pend_d;
  logic             have, pop, head, push, bp_fire, q_en;

  always_comb begin
    have    = (cnt_q != '0);
    pop     = retire & have;
    head    = have & tag_q[0];
    bp_fire = retire & (head | op_q);
    push    = fetch_vld & fetch_pre & ~flush;
    cnt_ap  = cnt_q - CW'(pop);

    tag_d = pop ? (tag_q >> 1) : tag_q;
    cnt_d = cnt_ap;
    if (push && (cnt_ap != CW'(DEPTH))) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cnt_ap == CW'(i)) tag_d[i] = bkpt_in;
      end
      cnt_d = cnt_ap + CW'(1);
    end
    if (flush) begin
      tag_d = '0;
      cnt_d = '0;
    end

    op_d   = ~flush & ((op_q & ~retire) | (fetch_vld & ~fetch_pre & bkpt_in));
    pend_d = (pend_q | bp_fire) & ~bp_grant;
    q_en   = push | pop | flush;
  end

  assign bp_want = pend_q | bp_fire;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tag_q[g] <= 1'b0;
      else if (q_en) tag_q[g] <= tag_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      op_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (q_en) cnt_q <= cnt_d;
      op_q   <= op_d;
      pend_q <= pend_d;
    end
  end

  AST_QUEUE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && fetch_pre && !flush && !pop) |-> (cnt_q != CW'(DEPTH))); // R2
  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0) && !op_q); // R4
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !bp_grant) |=> pend_q); // R11
endmodule

// File: rtl/cs_addr_enc.sv
module cs_addr_enc
  import cpu_space_pkg::*;
#(
  parameter logic [2:0] BKPT_NUM = 3'd7,
  parameter logic       BKPT_T   = 1'b1,
  parameter int         STOP_HI  = 17
) (
  input  cyc_kind_e           kind,
  input  logic [LVL_W-1:0]    level,
  output logic [CS_AW-1:0]    addr
);
  localparam logic [3:0] TYPE_BKPT = 4'b0000;

  function automatic logic [CS_AW-1:0] mk_bkpt();
    logic [CS_AW-1:0] a;
    a        = '0;
    a[19:16] = TYPE_BKPT;
    a[4:2]   = BKPT_NUM;
    a[1]     = BKPT_T;
    return a;
  endfunction

  function automatic logic [CS_AW-1:0] mk_stop();
    logic [CS_AW-1:0] a;
    a = '0;
    for (int i = 1; i <= STOP_HI; i++) a[i] = 1'b1;
    return a;
  endfunction

  localparam logic [CS_AW-1:0] BKPT_ADDR = mk_bkpt();
  localparam logic [CS_AW-1:0] STOP_ADDR = mk_stop();

  always_comb begin
    unique case (kind)
      CYC_BKPT: addr = BKPT_ADDR;
      CYC_IACK: addr = {{(CS_AW-LVL_W-1){1'b1}}, level, 1'b1};
      CYC_STOP: addr = STOP_ADDR;
      default:  addr = '0;
    endcase
  end
endmodule

// File: rtl/cs_bus_seq.sv
module cs_bus_seq
  import cpu_space_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bp_want,
  input  logic             iack_req,
  input  logic             stop_req,
  input  logic             term_ok,
  input  logic             term_err,
  input  logic [CS_AW-1:0] enc_addr,
  output cyc_kind_e        grant_kind,
  output logic             bp_grant,
  output logic             cs_req,
  output logic [FC_W-1:0]  cs_fc,
  output logic [CS_AW-1:0] cs_addr,
  output logic             bkpt_exc,
  output logic             cyc_done
);
  bus_state_e       state_q, state_d;
  cyc_kind_e        kind_q, kind_d;
  logic [CS_AW-1:0] addr_q, addr_d;
  logic [FC_W-1:0]  fc_q, fc_d;
  logic             exc_d, done_d, term;

  always_comb begin
    grant_kind = CYC_NONE;
    if (state_q == BUS_IDLE) begin
      if (bp_want)       grant_kind = CYC_BKPT;
      else if (iack_req) grant_kind = CYC_IACK;
      else if (stop_req) grant_kind = CYC_STOP;
    end
    bp_grant = (grant_kind == CYC_BKPT);
    term     = (state_q == BUS_ACTIVE) & (term_ok | term_err);

    state_d = state_q;
    kind_d  = kind_q;
    addr_d  = addr_q;
    fc_d    = fc_q;
    exc_d   = 1'b0;
    done_d  = 1'b0;
    if (grant_kind != CYC_NONE) begin
      state_d = BUS_ACTIVE;
      kind_d  = grant_kind;
      addr_d  = enc_addr;
      fc_d    = FC_CPU_SPACE;
    end else if (term) begin
      state_d = BUS_IDLE;
      kind_d  = CYC_NONE;
      addr_d  = '0;
      fc_d    = FC_NONE;
      exc_d   = (kind_q == CYC_BKPT);
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= BUS_IDLE;
      kind_q   <= CYC_NONE;
      addr_q   <= '0;
      fc_q     <= FC_NONE;
      bkpt_exc <= 1'b0;
      cyc_done <= 1'b0;
    end else begin
      state_q  <= state_d;
      kind_q   <= kind_d;
      addr_q   <= addr_d;
      fc_q     <= fc_d;
      bkpt_exc <= exc_d;
      cyc_done <= done_d;
    end
  end

  assign cs_req  = (state_q == BUS_ACTIVE);
  assign cs_addr = addr_q;
  assign cs_fc   = fc_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_req && !term_ok && !term_err) |=> cs_req); // R10
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_req && !term_ok && !term_err) |=> ($stable(cs_addr) && $stable(cs_fc))); // R10
  AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_exc |=> !bkpt_exc); // R6
  AST_EXC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_exc |-> $past(cs_req && (term_ok || term_err) && (kind_q == CYC_BKPT))); // R13
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    cs_req |-> (grant_kind == CYC_NONE)); // R11
  AST_BKPT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_want && !cs_req) |=> (cs_req && kind_q == CYC_BKPT)); // R9
  AST_IDLE_TERM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_req && !bp_want && !iack_req && !stop_req) |=> (!cs_req && !bkpt_exc && !cyc_done)); // R12
endmodule

// File: rtl/cpu_space_seq.sv
module cpu_space_seq
  import cpu_space_pkg::*;
#(
  parameter int         TAG_DEPTH = 4,
  parameter logic [2:0] BKPT_NUM  = 3'd7,
  parameter logic       BKPT_T    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic             rd_prefetch,
  input  logic             bkpt_in,
  input  logic             ins_retire,
  input  logic             pipe_flush,
  input  logic             iack_req,
  input  logic [2:0]       iack_level,
  input  logic             stop_req,
  input  logic             bus_ack,
  input  logic             bus_err,
  output logic             cs_req,
  output logic [2:0]       cs_fc,
  output logic [23:0]      cs_addr,
  output logic             bkpt_exc,
  output logic             cyc_done
);
  logic             rst_n_sync;
  logic             bp_want, bp_grant;
  cyc_kind_e        grant_kind;
  logic [CS_AW-1:0] enc_addr;

  cs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cs_bkpt_tagger #(.DEPTH(TAG_DEPTH)) u_tag (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .fetch_vld (rd_valid),
    .fetch_pre (rd_prefetch),
    .bkpt_in   (bkpt_in),
    .retire    (ins_retire),
    .flush     (pipe_flush),
    .bp_grant  (bp_grant),
    .bp_want   (bp_want)
  );

  cs_addr_enc #(.BKPT_NUM(BKPT_NUM), .BKPT_T(BKPT_T), .STOP_HI(17)) u_enc (
    .kind  (grant_kind),
    .level (iack_level),
    .addr  (enc_addr)
  );

  cs_bus_seq u_bus (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .bp_want    (bp_want),
    .iack_req   (iack_req),
    .stop_req   (stop_req),
    .term_ok    (bus_ack),
    .term_err   (bus_err),
    .enc_addr   (enc_addr),
    .grant_kind (grant_kind),
    .bp_grant   (bp_grant),
    .cs_req     (cs_req),
    .cs_fc      (cs_fc),
    .cs_addr    (cs_addr),
    .bkpt_exc   (bkpt_exc),
    .cyc_done   (cyc_done)
  );
endmodule

// File: tb/tb_cpu_space_seq.sv
module tb_cpu_space_seq;
  logic clk, rst_n;
  logic rd_valid, rd_prefetch, bkpt_in, ins_retire, pipe_flush;
  logic iack_req, stop_req, bus_ack, bus_err;
  logic [2:0] iack_level;
  logic cs_req, bkpt_exc, cyc_done;
  logic [2:0] cs_fc;
  logic [23:0] cs_addr;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  localparam logic [23:0] A_BKPT = 24'h00001E;
  localparam logic [23:0] A_STOP = 24'h03FFFE;

  cpu_space_seq dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_prefetch(rd_prefetch),
    .bkpt_in(bkpt_in), .ins_retire(ins_retire), .pipe_flush(pipe_flush),
    .iack_req(iack_req), .iack_level(iack_level), .stop_req(stop_req),
    .bus_ack(bus_ack), .bus_err(bus_err), .cs_req(cs_req), .cs_fc(cs_fc),
    .cs_addr(cs_addr), .bkpt_exc(bkpt_exc), .cyc_done(cyc_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic fetch(input logic pre, input logic bk);
    rd_valid = 1; rd_prefetch = pre; bkpt_in = bk;
    cyc();
    rd_valid = 0; rd_prefetch = 0; bkpt_in = 0;
  endtask

  task automatic retire_one();
    ins_retire = 1;
    cyc();
    ins_retire = 0;
  endtask

  task automatic flush_pipe();
    pipe_flush = 1;
    cyc();
    pipe_flush = 0;
  endtask

  task automatic terminate(input logic err);
    if (err) bus_err = 1; else bus_ack = 1;
    cyc();
    bus_ack = 0; bus_err = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) cyc();
    check("R1 req in reset", 32'(cs_req), 0);
    check("R1 addr in reset", 32'(cs_addr), 0);
    check("R1 fc in reset", 32'(cs_fc), 0);
    rst_n = 1;
    repeat (4) cyc();
    check("R1 req after reset", 32'(cs_req), 0);
    check("R1 exc after reset", 32'(bkpt_exc), 0);
    check("R1 done after reset", 32'(cyc_done), 0);
  endtask

  task automatic t_prefetch();
    flush_pipe();
    fetch(1, 0);
    fetch(1, 1);
    retire_one();
    check("R2 untagged retire", 32'(cs_req), 0);
    retire_one();
    check("R2 req after tagged retire", 32'(cs_req), 1);
    check("R5 bkpt addr", 32'(cs_addr), 32'(A_BKPT));
    check("R5 bkpt fc", 32'(cs_fc), 7);
    repeat (3) begin
      cyc();
      check("R10 req held", 32'(cs_req), 1);
      check("R10 addr stable", 32'(cs_addr), 32'(A_BKPT));
    end
    terminate(0);
    check("R6 req drops", 32'(cs_req), 0);
    check("R6 exc on ack", 32'(bkpt_exc), 1);
    check("R13 done", 32'(cyc_done), 1);
    cyc();
    check("R6 exc one cycle", 32'(bkpt_exc), 0);
    check("R12 idle addr", 32'(cs_addr), 0);
    check("R12 idle fc", 32'(cs_fc), 0);
  endtask

  task automatic t_operand();
    flush_pipe();
    fetch(1, 0);
    fetch(1, 0);
    fetch(0, 1);
    cyc();
    check("R3 not before retire", 32'(cs_req), 0);
    retire_one();
    check("R3 req after retire", 32'(cs_req), 1);
    check("R3 addr", 32'(cs_addr), 32'(A_BKPT));
    terminate(1);
    check("R6 exc on error", 32'(bkpt_exc), 1);
    check("R6 req drops on error", 32'(cs_req), 0);
  endtask

  task automatic t_flush();
    flush_pipe();
    fetch(1, 1);
    fetch(0, 1);
    flush_pipe();
    for (int i = 0; i < 3; i++) begin
      retire_one();
      check("R4 no ack after flush", 32'(cs_req), 0);
    end
    fetch(1, 0);
    rd_valid = 1; rd_prefetch = 1; bkpt_in = 1; pipe_flush = 1;
    cyc();
    rd_valid = 0; rd_prefetch = 0; bkpt_in = 0; pipe_flush = 0;
    retire_one();
    retire_one();
    check("R4 same-cycle tag dropped", 32'(cs_req), 0);
  endtask

  task automatic t_iack(input logic [2:0] lvl, input logic [23:0] exp_addr);
    iack_req = 1; iack_level = lvl;
    cyc();
    check("R7 iack req", 32'(cs_req), 1);
    check("R7 iack addr", 32'(cs_addr), 32'(exp_addr));
    check("R7 iack fc", 32'(cs_fc), 7);
    terminate(0);
    check("R13 iack done", 32'(cyc_done), 1);
    check("R13 iack no exc", 32'(bkpt_exc), 0);
    iack_req = 0;
    cyc();
  endtask

  task automatic t_stop();
    stop_req = 1;
    cyc();
    check("R8 stop addr", 32'(cs_addr), 32'(A_STOP));
    check("R8 stop fc", 32'(cs_fc), 7);
    terminate(1);
    check("R13 stop done", 32'(cyc_done), 1);
    check("R13 stop no exc", 32'(bkpt_exc), 0);
    stop_req = 0;
    cyc();
  endtask

  task automatic t_priority();
    flush_pipe();
    fetch(1, 1);
    ins_retire = 1; iack_req = 1; iack_level = 3'd1; stop_req = 1;
    cyc();
    ins_retire = 0;
    check("R9 bkpt first", 32'(cs_addr), 32'(A_BKPT));
    terminate(0);
    check("R9 bkpt exc", 32'(bkpt_exc), 1);
    cyc();
    check("R9 iack second", 32'(cs_addr), 32'h00FFFFF3);
    terminate(0);
    iack_req = 0;
    cyc();
    check("R9 stop third", 32'(cs_addr), 32'(A_STOP));
    terminate(0);
    stop_req = 0;
    cyc();
    check("R9 all served", 32'(cs_req), 0);
  endtask

  task automatic t_busy();
    flush_pipe();
    fetch(1, 1);
    stop_req = 1;
    cyc();
    check("R11 stop running", 32'(cs_addr), 32'(A_STOP));
    retire_one();
    check("R11 no preempt", 32'(cs_addr), 32'(A_STOP));
    terminate(0);
    stop_req = 0;
    check("R11 gap req", 32'(cs_req), 0);
    check("R11 gap exc", 32'(bkpt_exc), 0);
    cyc();
    check("R11 held ack starts", 32'(cs_req), 1);
    check("R11 held ack addr", 32'(cs_addr), 32'(A_BKPT));
    terminate(0);
    check("R11 held ack exc", 32'(bkpt_exc), 1);
    cyc();
  endtask

  task automatic t_idle_term();
    bus_ack = 1; bus_err = 1;
    cyc(); cyc();
    bus_ack = 0; bus_err = 0;
    check("R12 idle term req", 32'(cs_req), 0);
    check("R12 idle term exc", 32'(bkpt_exc), 0);
    check("R12 idle term done", 32'(cyc_done), 0);
  endtask

  initial begin
    rst_n = 0; rd_valid = 0; rd_prefetch = 0; bkpt_in = 0; ins_retire = 0;
    pipe_flush = 0; iack_req = 0; iack_level = 0; stop_req = 0;
    bus_ack = 0; bus_err = 0;
    t_reset();
    t_prefetch();
    t_operand();
    t_flush();
    t_iack(3'd5, 24'hFFFFFB);
    t_iack(3'd2, 24'hFFFFF5);
    t_stop();
    t_priority();
    t_busy();
    t_idle_term();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule